// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is a slave receiver for a two-channel serial audio link. A remote transmitter supplies the bit clock, the channel clock and the data line. The receiver oversamples all three with its own system clock, takes one data bit on every rising bit-clock edge, and rebuilds each stereo pair as two parallel words of a fixed parameter width. It then presents the pair with a one-cycle strobe.

Four framing styles are selected by a two-bit format input. A single polarity input has two jobs. In the three channel-clock styles it inverts which clock level means left. In the pulse-framed style it chooses whether data starts on the frame pulse or one bit later. A new format or polarity waits for a frame boundary before it takes effect, and the frame that is open at that moment is discarded.

Top module: `audio_serial_rx`

## Requirements
- R1: While rst_ni is low, and after its release until the first pair, left_o and right_o are zero and valid_o is low; the active format is right-justified with polarity 0.
- R2: Bits are taken on rising bit-clock edges only. valid_o is high for exactly one clock, never two in a row, and left_o/right_o change only in a cycle where valid_o is high.
- R3: Format code 01 (left-justified): with polarity 0 left is channel clock high. The MSB is the bit at which the channel clock changes level, the next DW-1 bits complete the word, and later bits in the slot are ignored.
- R4: Format code 10 (I2S): with polarity 0 left is channel clock low. The MSB is the bit one bit clock after the channel clock changes level.
- R5: Format code 00 (right-justified): with polarity 0 left is channel clock high. A word is the last DW bits before the channel clock changes level, and earlier bits in a longer slot are discarded. The pair is output at the right-to-left change.
- R6: In codes 00, 01 and 10, polarity 1 swaps the channel clock level that means left, so the same words are recovered from a stream whose channel clock is inverted.
- R7: Format code 11 with polarity 0 (pulse-framed, early): a one-bit-high channel clock pulse marks a frame. The left MSB is on the bit after the pulse and the right word follows the left word's LSB with no gap.
- R8: Format code 11 with polarity 1 (pulse-framed, late): the left MSB is on the pulse bit itself; the right word follows at once.
- R9: A change on fmt_i/pol_i takes effect at the next bit on which the sampled channel clock goes from 0 to 1. Until then the old format decodes, and no pair is output for the frame that starts at that bit.
- R10: If a right-justified pair completes on the same bit that applies a format change, that pair is still output, decoded in the old format.
- R11: A pair is output only when a left word has been captured before the right word since the last format change; a right word on its own produces nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock from the transmitter |
| chclk_i | input | 1 | Channel clock or frame pulse |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Format code: 00 right-justified, 01 left-justified, 10 I2S, 11 pulse-framed |
| pol_i | input | 1 | Channel-clock inversion, or early/late select in pulse-framed mode |
| left_o | output | DW | Last received left word |
| right_o | output | DW | Last received right word |
| valid_o | output | 1 | One-cycle strobe when a new pair is on left_o/right_o |

## Verification
The case to watch is a format change that lands on the same bit as the completion of a right-justified pair. The right-to-left channel-clock edge both ends that pair and is the rising edge that applies the new format. The bench provokes it by changing fmt_i from right-justified to left-justified during the right slot of a frame. It then requires that the ending frame still comes out with right-justified decoding, that the next frame (already in the new layout) is dropped, and that the frame after that decodes as left-justified. A second sequence changes format in the middle of a left-justified frame, to show that the change is deferred and that a lone right word is not turned into a pair.

// File: rtl/audio_serial_rx_pkg.sv
package audio_serial_rx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic pol;
  } cfg_t;
endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic chclk_i,
  input  logic sdata_i,
  output logic tick_o,
  output logic ch_o,
  output logic sd_o
);
  // lane 0 bit clock, lane 1 channel clock, lane 2 data
  logic [2:0] stg_q [STAGES];
  logic       bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      bclk_q <= 1'b0;
    end else begin
      stg_q[0] <= {sdata_i, chclk_i, bclk_i};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      bclk_q <= stg_q[STAGES-1][0];
    end
  end

  assign tick_o = stg_q[STAGES-1][0] & ~bclk_q;
  assign ch_o   = stg_q[STAGES-1][1];
  assign sd_o   = stg_q[STAGES-1][2];
endmodule

// File: rtl/asr_deframe.sv
module asr_deframe
  import audio_serial_rx_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ch_i,
  input  logic          sd_i,
  input  cfg_t          cfg_req_i,
  output logic [DW-1:0] word_o,
  output logic          done_o,
  output logic          is_left_o,
  output logic          apply_o,
  output cfg_t          cfg_o
);
  localparam int CW = $clog2(2*DW + 1);
  localparam logic [CW-1:0] W1   = CW'(DW);
  localparam logic [CW-1:0] W2   = CW'(2*DW);
  localparam logic [CW-1:0] IDLE = W2;

  cfg_t          cfg_q;
  logic          ch_d, eff_q, primed_q;
  logic [CW-1:0] cnt_q, cnt_nxt, lim;
  logic [DW-1:0] sh_q;
  logic          dsp, i2s, rj, eff, lvl_left, prev_left, chan_edge, start, run;

  always_comb begin
    dsp       = cfg_q.fmt == FMT_DSP;
    i2s       = cfg_q.fmt == FMT_I2S;
    rj        = cfg_q.fmt == FMT_RJ;
    // I2S and early pulse framing see the channel clock one bit late
    eff       = (i2s || (dsp && !cfg_q.pol)) ? ch_d : ch_i;
    lvl_left  = (i2s ? ~eff : eff) ^ cfg_q.pol;
    prev_left = (i2s ? ~eff_q : eff_q) ^ cfg_q.pol;
    chan_edge = eff ^ eff_q;
    start     = dsp ? (eff & ~eff_q) : chan_edge;
    lim       = dsp ? W2 : W1;
    run       = start || (cnt_q < lim);
    cnt_nxt   = start ? CW'(1) : ((cnt_q < lim) ? cnt_q + CW'(1) : cnt_q);
    if (rj) begin
      word_o    = sh_q;
      done_o    = tick_i && chan_edge && primed_q;
      is_left_o = prev_left;
    end else begin
      word_o    = {sh_q[DW-2:0], sd_i};
      done_o    = tick_i && run && ((cnt_nxt == W1) || (dsp && cnt_nxt == W2));
      is_left_o = dsp ? (cnt_nxt == W1) : lvl_left;
    end
    apply_o = tick_i && (cfg_req_i != cfg_q) && ch_i && !ch_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '{fmt: FMT_RJ, pol: 1'b0};
      ch_d     <= 1'b0;
      eff_q    <= 1'b0;
      primed_q <= 1'b0;
      cnt_q    <= IDLE;
      sh_q     <= '0;
    end else if (tick_i) begin
      sh_q  <= {sh_q[DW-2:0], sd_i};
      ch_d  <= ch_i;
      eff_q <= eff;
      cnt_q <= cnt_nxt;
      if (start) primed_q <= 1'b1;
      if (apply_o) begin
        cfg_q    <= cfg_req_i;
        cnt_q    <= IDLE;
        primed_q <= 1'b0;
        eff_q    <= ch_i;
        ch_d     <= ch_i;
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/asr_pair.sv
module asr_pair #(
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          is_left_i,
  input  logic [DW-1:0] word_i,
  input  logic          flush_i,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o
);
  logic [DW-1:0] hold_q;
  logic          have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      have_q  <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_i) begin
        if (is_left_i) begin
          hold_q <= word_i;
          have_q <= 1'b1;
        end else if (have_q) begin
          left_o  <= hold_q;
          right_o <= word_i;
          valid_o <= 1'b1;
          have_q  <= 1'b0;
        end
      end
      // a completed pair on the applying bit is kept; the open frame is not
      if (flush_i) have_q <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audio_serial_rx_pkg::*;
#(
  parameter int DW          = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bclk_i,
  input  logic          chclk_i,
  input  logic          sdata_i,
  input  logic [1:0]    fmt_i,
  input  logic          pol_i,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o
);
  logic          bit_tick, ch_s, sd_s, w_done, w_left, apply;
  logic [DW-1:0] w_data;
  cfg_t          cfg_req, cfg_act;

  assign cfg_req = '{fmt: fmt_e'(fmt_i), pol: pol_i};

  asr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .bclk_i, .chclk_i, .sdata_i,
    .tick_o(bit_tick), .ch_o(ch_s), .sd_o(sd_s)
  );

  asr_deframe #(.DW(DW)) u_deframe (
    .clk_i, .rst_ni, .tick_i(bit_tick), .ch_i(ch_s), .sd_i(sd_s),
    .cfg_req_i(cfg_req), .word_o(w_data), .done_o(w_done),
    .is_left_o(w_left), .apply_o(apply), .cfg_o(cfg_act)
  );

  asr_pair #(.DW(DW)) u_pair (
    .clk_i, .rst_ni, .done_i(w_done), .is_left_i(w_left), .word_i(w_data),
    .flush_i(apply), .left_o, .right_o, .valid_o
  );
endmodule

// File: rtl/asr_checker.sv
module asr_checker
  import audio_serial_rx_pkg::*;
#(
  parameter int DW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [DW-1:0] left_i,
  input logic [DW-1:0] right_i,
  input logic          tick_i,
  input cfg_t          cfg_i
);
  assert_valid_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  assert_left_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(left_i));

  assert_right_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(right_i));

  assert_valid_follows_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(tick_i));

  assert_cfg_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cfg_i));
endmodule

bind audio_serial_rx asr_checker #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_o), .left_i(left_o),
  .right_i(right_o), .tick_i(bit_tick), .cfg_i(cfg_act)
);

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;
  localparam int DW = 24;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bclk_i = 1'b0, chclk_i = 1'b0, sdata_i = 1'b0, pol_i = 1'b0;
  logic [1:0] fmt_i = 2'b00;
  logic [DW-1:0] left_o, right_o;
  logic valid_o;

  int checks = 0, fails = 0, pc = 0, dbl = 0;
  logic prev_v = 1'b0;
  logic [DW-1:0] got_l [64];
  logic [DW-1:0] got_r [64];

  always #4 clk = ~clk;

  audio_serial_rx #(.DW(DW)) uut (
    .clk_i(clk), .rst_ni, .bclk_i, .chclk_i, .sdata_i, .fmt_i, .pol_i,
    .left_o, .right_o, .valid_o
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (valid_o) begin
        got_l[pc % 64] = left_o;
        got_r[pc % 64] = right_o;
        pc++;
        if (prev_v) dbl++;
      end
      prev_v = valid_o;
    end
  end

  // fmt, pol, left, right
  localparam logic [50:0] VECS [8] = '{
    {2'b00, 1'b0, 24'h123456, 24'hABCDEF},
    {2'b00, 1'b1, 24'h800001, 24'h7FFFFE},
    {2'b01, 1'b0, 24'hC0FFEE, 24'h0F1E2D},
    {2'b01, 1'b1, 24'h000001, 24'hFFFFFF},
    {2'b10, 1'b0, 24'h96A5C3, 24'h3C5A69},
    {2'b10, 1'b1, 24'hFEDCBA, 24'h010203},
    {2'b11, 1'b0, 24'hA1B2C3, 24'h4D5E6F},
    {2'b11, 1'b1, 24'h8000FF, 24'hFF0001}
  };

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] f, input logic p);
    if (f == 2'b11) return p ? "R8" : "R7";
    if (p) return "R6";
    case (f)
      2'b00:   return "R5";
      2'b01:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic send_bit(input logic c, input logic d);
    @(negedge clk);
    bclk_i = 1'b0; chclk_i = c; sdata_i = d;
    repeat (4) @(negedge clk);
    bclk_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_slot(input logic [1:0] f, input logic p, input logic is_r,
                           input logic [DW-1:0] w);
    logic lvl;
    lvl = ((f == 2'b10) ? is_r : ~is_r) ^ p;
    for (int k = 0; k < 32; k++) begin
      logic b;
      b = k[0];
      if (f == 2'b01 && k < DW) b = w[DW-1-k];
      if (f == 2'b10 && k >= 1 && k <= DW) b = w[DW-k];
      if (f == 2'b00 && k >= 32-DW) b = w[31-k];
      send_bit(lvl, b);
    end
  endtask

  task automatic send_dsp(input logic p, input logic [DW-1:0] l, input logic [DW-1:0] r);
    logic [2*DW-1:0] fr;
    fr = {l, r};
    for (int k = 0; k < 64; k++) begin
      int d;
      logic b;
      d = p ? k : k - 1;
      b = k[0];
      if (d >= 0 && d < 2*DW) b = fr[2*DW-1-d];
      send_bit(k == 0, b);
    end
  endtask

  task automatic send_frame(input logic [1:0] f, input logic p,
                            input logic [DW-1:0] l, input logic [DW-1:0] r);
    if (f == 2'b11) send_dsp(p, l, r);
    else begin
      send_slot(f, p, 1'b0, l);
      send_slot(f, p, 1'b1, r);
    end
  endtask

  task automatic send_tail(input logic [1:0] f, input logic p);
    if (f == 2'b11) for (int k = 0; k < 32; k++) send_bit(1'b0, k[0]);
    else send_slot(f, p, 1'b0, '0);
  endtask

  task automatic run_case(input logic [1:0] f, input logic p,
                          input logic [DW-1:0] l, input logic [DW-1:0] r);
    int base;
    string rq;
    rq = req_of(f, p);
    fmt_i = f; pol_i = p;
    send_frame(f, p, 24'h5A5A5A, 24'hA5A5A5);
    send_frame(f, p, 24'h5A5A5A, 24'hA5A5A5);
    base = pc;
    send_frame(f, p, l, r);
    send_frame(f, p, r, l);
    send_tail(f, p);
    repeat (20) @(negedge clk);
    checks++;
    if (pc - base < 2) begin
      fails++;
      $display("FAIL %s pairs got=%0d exp>=2", rq, pc - base);
    end
    chk(rq, got_l[(pc-2) % 64], l);
    chk(rq, got_r[(pc-2) % 64], r);
    chk(rq, got_l[(pc-1) % 64], r);
    chk(rq, got_r[(pc-1) % 64], l);
  endtask

  initial begin
    int base;
    repeat (5) @(negedge clk);
    chk("R1", left_o, '0);
    chk("R1", right_o, '0);
    chk("R1", {23'd0, valid_o}, '0);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1", {23'd0, valid_o}, '0);

    for (int i = 0; i < 8; i++)
      run_case(VECS[i][50:49], VECS[i][48], VECS[i][47:24], VECS[i][23:0]);

    // R9/R11: change deferred mid-frame, frame at the applying edge dropped
    run_case(2'b01, 1'b0, 24'h111111, 24'h222222);
    send_slot(2'b01, 1'b0, 1'b1, 24'h0);
    repeat (20) @(negedge clk);
    base = pc;
    send_slot(2'b01, 1'b0, 1'b0, 24'hA0A0A1);
    fmt_i = 2'b00;
    send_slot(2'b01, 1'b0, 1'b1, 24'hB0B0B2);
    send_frame(2'b00, 1'b0, 24'hDEAD01, 24'hDEAD02);
    send_frame(2'b00, 1'b0, 24'hC3C3C4, 24'h5C5C5D);
    send_tail(2'b00, 1'b0);
    repeat (20) @(negedge clk);
    chk_cnt("R11", pc - base, 2);
    chk("R9", got_l[base % 64], 24'hA0A0A1);
    chk("R9", got_r[base % 64], 24'hB0B0B2);
    chk("R9", got_l[(base+1) % 64], 24'hC3C3C4);
    chk("R9", got_r[(base+1) % 64], 24'h5C5C5D);

    // R10: right-justified pair completes on the bit that applies the change
    base = pc;
    send_slot(2'b00, 1'b0, 1'b0, 24'h13579B);
    fmt_i = 2'b01;
    send_slot(2'b00, 1'b0, 1'b1, 24'h2468AC);
    send_frame(2'b01, 1'b0, 24'hBAD001, 24'hBAD002);
    send_frame(2'b01, 1'b0, 24'h6E6E6F, 24'h9F9F90);
    send_tail(2'b01, 1'b0);
    repeat (20) @(negedge clk);
    chk_cnt("R10", pc - base, 2);
    chk("R10", got_l[base % 64], 24'h13579B);
    chk("R10", got_r[base % 64], 24'h2468AC);
    chk("R10", got_l[(base+1) % 64], 24'h6E6E6F);
    chk("R10", got_r[(base+1) % 64], 24'h9F9F90);

    // R2: outputs held after the last pair, strobe never two cycles wide
    repeat (50) @(negedge clk);
    chk("R2", left_o, 24'h6E6E6F);
    chk("R2", right_o, 24'h9F9F90);
    chk_cnt("R2", dbl, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule